// File: doc/BRIEF.md
# Parallel EEPROM Write Capture Unit

This block is a synchronous, device-side model of the control logic in a byte-wide parallel EEPROM. A fast system clock samples the three active-low strobes: chip select, write enable and output enable. Each strobe passes through a two-flop synchronizer, and edges are detected on the synchronized values. From these values the block decodes the bus mode: standby, read, write, output-off or write-inhibit. It captures the address when a write starts and the data when the write ends. Because of this, the capture points follow whichever strobe falls last and whichever strobe rises first.

Every falling edge of write enable restarts a page window timer. The timer acts as a retriggerable one-shot, so bytes written back to back form a page. When the window runs out after at least one captured byte, the block enters a programming-busy phase of fixed length. While busy, a read returns the last captured byte with its top bit inverted, so software can poll for the end of the write. Strobes are ignored for the whole busy phase. When the block is not busy, reads pass through the array data presented on `arr_q_i`. Each captured byte appears as a one-cycle strobe with its address and data, ready for an external page buffer.

The controller has four states:
- `ST_IDLE`: leaves on a write start (to `ST_ARMED`) or on a write-enable fall (to `ST_WINDOW`).
- `ST_ARMED`: the write is in progress and the address is held. It returns to `ST_WINDOW` when the write condition drops, with a capture if output enable is still high and an abort otherwise.
- `ST_WINDOW`: the page window is open. It moves to `ST_ARMED` on a new write start, to `ST_PROG` on expiry with a byte pending, and to `ST_IDLE` on expiry with nothing pending.
- `ST_PROG`: programming is busy. It returns to `ST_IDLE` when the programming count reaches zero.

Top module: `pee_write_capture`

## Requirements
- R1: After reset, `busy_o`, `rd_oe_o` and `cap_stb_o` are 0 and `mode_o` is standby (0).
- R2: `mode_o` decodes the synchronized strobes as follows, and `rd_oe_o` is 1 only in read:
  - chip select high gives standby (0);
  - chip select low, output enable low and write enable high gives read (1);
  - chip select low, output enable high and write enable low gives write (2);
  - chip select low with output enable and write enable both high gives output-off (3);
  - chip select low with output enable and write enable both low gives inhibit (4).
- R3: `cap_addr_o` takes the `addr_i` value sampled in the cycle the decoded mode becomes write, which is the later of the two strobe falls. Later address changes do not alter it.
- R4: When the write ends through the earlier of the two strobe rises, with output enable high, `cap_data_o` takes `data_i` from that cycle and `cap_stb_o` pulses for exactly one cycle.
- R5: If output enable goes low while both strobes are low, the write is dropped: no `cap_stb_o` pulse is produced.
- R6: Each synchronized write-enable fall, outside the busy phase, reloads the page timer with `PAGE_CYC`. Programming starts only after the timer has counted down to zero with no new fall.
- R7: `busy_o` stays high for exactly `PROG_CYC` consecutive cycles, then the block returns to idle.
- R8: In read mode while busy, `rd_data_o` equals the last captured byte with bit `DATA_W-1` inverted. When not busy, `rd_data_o` equals `arr_q_i`.
- R9: While busy, strobes cause no capture, no address latch and no page-timer reload.
- R10: A page window that expires with no captured byte returns to idle without raising `busy_o`.
- R11: Each strobe input passes through two synchronizer flops. A change therefore shows on `mode_o` after the second rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Chip select, active low, asynchronous |
| we_n_i | input | 1 | Write enable, active low, asynchronous |
| oe_n_i | input | 1 | Output enable, active low, asynchronous |
| addr_i | input | ADDR_W | Address bus |
| data_i | input | DATA_W | Write data bus |
| arr_q_i | input | DATA_W | Data read from the storage array |
| mode_o | output | 3 | Decoded bus mode (encoding in R2) |
| rd_oe_o | output | 1 | Read data drive enable |
| rd_data_o | output | DATA_W | Read data, or polling status while busy |
| cap_stb_o | output | 1 | One-cycle pulse per captured byte |
| cap_addr_o | output | ADDR_W | Captured write address |
| cap_data_o | output | DATA_W | Captured write data |
| busy_o | output | 1 | Programming phase in progress |

## Verification
The hardest situation to reach is the page-window boundary. A new write-enable fall must arrive while the timer is still counting, and programming must follow exactly one full window after the last fall. The bench reaches it with a burst of write-enable-controlled writes whose fall-to-fall spacing is shorter than the shortened window, followed by a quiet gap. A behavioural reference, fed the same raw strobes through a sample-history queue, predicts the cycle in which busy rises. The same run probes the other corners: chip-select-controlled writes, an output-enable drop in the middle of a write, and strobe activity inside the busy phase.

// File: rtl/pee_pkg.sv
package pee_pkg;

    typedef enum logic [2:0] {
        MODE_STANDBY = 3'd0,
        MODE_READ    = 3'd1,
        MODE_WRITE   = 3'd2,
        MODE_OUT_OFF = 3'd3,
        MODE_INHIBIT = 3'd4
    } pee_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WINDOW = 2'd1,
        ST_ARMED  = 2'd2,
        ST_PROG   = 2'd3
    } pee_state_e;

endpackage

// File: rtl/pee_strobe_sync.sv
module pee_strobe_sync #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stab_q;

    // Idle level of every active-low strobe is high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '1;
            stab_q <= '1;
        end else begin
            meta_q <= raw_i;
            stab_q <= meta_q;
        end
    end

    assign sync_o = stab_q;
endmodule

// File: rtl/pee_downcount.sv
module pee_downcount #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic [W-1:0] cnt_o,
    output logic         zero_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign cnt_o  = cnt_q;
    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pee_write_capture.sv
module pee_write_capture
    import pee_pkg::*;
#(
    parameter int ADDR_W   = 17,
    parameter int DATA_W   = 8,
    parameter int PAGE_CYC = 30000,
    parameter int PROG_CYC = 2000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_i,
    input  logic              we_n_i,
    input  logic              oe_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [DATA_W-1:0] arr_q_i,
    output logic [2:0]        mode_o,
    output logic              rd_oe_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              cap_stb_o,
    output logic [ADDR_W-1:0] cap_addr_o,
    output logic [DATA_W-1:0] cap_data_o,
    output logic              busy_o
);
    localparam int MAX_CYC  = (PAGE_CYC > PROG_CYC) ? PAGE_CYC : PROG_CYC;
    localparam int CNT_W    = $clog2(MAX_CYC + 1);
    localparam int POLL_BIT = DATA_W - 1;

    // ---------------- strobe synchronizers ----------------
    logic [2:0] strobe_sync;
    logic       cs_s, we_s, oe_s;

    pee_strobe_sync #(.WIDTH(3)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({cs_n_i, we_n_i, oe_n_i}),
        .sync_o (strobe_sync)
    );

    assign cs_s = strobe_sync[2];
    assign we_s = strobe_sync[1];
    assign oe_s = strobe_sync[0];

    // ---------------- mode decode ----------------
    pee_mode_e mode;

    always_comb begin
        if (cs_s)              mode = MODE_STANDBY;
        else if (!oe_s && we_s) mode = MODE_READ;
        else if (oe_s && !we_s) mode = MODE_WRITE;
        else if (oe_s && we_s)  mode = MODE_OUT_OFF;
        else                    mode = MODE_INHIBIT;
    end

    // ---------------- edge detection ----------------
    logic we_prev_q, act_prev_q;
    logic wr_act, wr_start, we_fall;

    assign wr_act   = (mode == MODE_WRITE);
    assign wr_start = wr_act && !act_prev_q;
    assign we_fall  = we_prev_q && !we_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_prev_q  <= 1'b1;
            act_prev_q <= 1'b0;
        end else begin
            we_prev_q  <= we_s;
            act_prev_q <= wr_act;
        end
    end

    // ---------------- timers ----------------
    pee_state_e   state_q, state_n;
    logic [CNT_W-1:0] win_cnt, prog_cnt;
    logic         win_zero, prog_zero, win_load, prog_load;

    assign win_load  = we_fall && (state_q != ST_PROG);
    assign prog_load = (state_n == ST_PROG) && (state_q != ST_PROG);

    pee_downcount #(.W(CNT_W)) u_page_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (win_load),
        .val_i  (CNT_W'(PAGE_CYC)),
        .cnt_o  (win_cnt),
        .zero_o (win_zero)
    );

    pee_downcount #(.W(CNT_W)) u_prog (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (prog_load),
        .val_i  (CNT_W'(PROG_CYC - 1)),
        .cnt_o  (prog_cnt),
        .zero_o (prog_zero)
    );

    // ---------------- state machine ----------------
    logic have_byte_q;
    logic do_addr, do_cap;

    always_comb begin
        state_n = state_q;
        do_addr = 1'b0;
        do_cap  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_start) begin
                    state_n = ST_ARMED;
                    do_addr = 1'b1;
                end else if (we_fall) begin
                    state_n = ST_WINDOW;
                end
            end
            ST_WINDOW: begin
                if (wr_start) begin
                    state_n = ST_ARMED;
                    do_addr = 1'b1;
                end else if (win_zero && !we_fall) begin
                    state_n = have_byte_q ? ST_PROG : ST_IDLE;
                end
            end
            ST_ARMED: begin
                if (!wr_act) begin
                    state_n = ST_WINDOW;
                    do_cap  = oe_s;
                end
            end
            ST_PROG: begin
                if (prog_zero) state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // ---------------- captured data and outputs ----------------
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              stb_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q      <= '0;
            data_q      <= '0;
            stb_q       <= 1'b0;
            have_byte_q <= 1'b0;
        end else begin
            stb_q <= do_cap;
            if (do_addr) addr_q <= addr_i;
            if (do_cap)  data_q <= data_i;
            if (do_cap)
                have_byte_q <= 1'b1;
            else if (state_n == ST_IDLE || state_n == ST_PROG)
                have_byte_q <= 1'b0;
        end
    end

    always_comb begin
        mode_o     = mode;
        rd_oe_o    = (mode == MODE_READ);
        busy_o     = (state_q == ST_PROG);
        cap_stb_o  = stb_q;
        cap_addr_o = addr_q;
        cap_data_o = data_q;
        if (state_q == ST_PROG)
            rd_data_o = {~data_q[POLL_BIT], data_q[POLL_BIT-1:0]};
        else
            rd_data_o = arr_q_i;
    end

    // ---------------- assertions ----------------
    AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |-> !rd_oe_o);                                               // R2
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && $past(state_q == ST_ARMED)) |-> $stable(cap_addr_o)); // R3
    AST_CAP_FROM_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        cap_stb_o |-> ($past(state_q == ST_ARMED) && $past(oe_s)));       // R4
    AST_PROG_AFTER_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(win_zero));                               // R6
    AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (prog_cnt < CNT_W'(PROG_CYC)));                        // R7
    AST_BUSY_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !cap_stb_o);                                           // R9
    AST_BUSY_TIMER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> win_zero);                                             // R9
    AST_WIN_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (we_fall && !busy_o) |=> (win_cnt == CNT_W'(PAGE_CYC)));          // R6

endmodule

// File: tb/tb_pee_write_capture.sv
`timescale 1ns/1ps
module tb_pee_write_capture;
    localparam int AW = 17;
    localparam int DW = 8;
    localparam int PG = 16;
    localparam int PR = 30;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] arr_q = 8'h3C;
    logic [2:0]    mode_o;
    logic          rd_oe_o, cap_stb_o, busy_o;
    logic [DW-1:0] rd_data_o, cap_data_o;
    logic [AW-1:0] cap_addr_o;

    int compared = 0;
    int mismatched = 0;

    always #2.5 clk = ~clk;

    pee_write_capture #(.ADDR_W(AW), .DATA_W(DW), .PAGE_CYC(PG), .PROG_CYC(PR)) dut (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .we_n_i(we_n), .oe_n_i(oe_n),
        .addr_i(addr), .data_i(din), .arr_q_i(arr_q),
        .mode_o(mode_o), .rd_oe_o(rd_oe_o), .rd_data_o(rd_data_o),
        .cap_stb_o(cap_stb_o), .cap_addr_o(cap_addr_o), .cap_data_o(cap_data_o),
        .busy_o(busy_o)
    );

    // ---------------- behavioural reference ----------------
    // sample history, entry 0 = newest sample, bits {cs, we, oe}
    logic [2:0] hist[$] = '{3'b111, 3'b111, 3'b111};
    int m_state = 0;          // 0 idle, 1 page open, 2 strobes low, 3 busy
    int m_win = 0;
    int m_prog = 0;
    bit m_have = 0;
    bit m_stb = 0;
    logic [AW-1:0] m_addr = '0;
    logic [DW-1:0] m_data = '0;

    function automatic int dec_mode(logic [2:0] s);
        if (s[2])                return 0;
        else if (!s[0] && s[1])  return 1;
        else if (s[0] && !s[1])  return 2;
        else if (s[0] && s[1])   return 3;
        else                     return 4;
    endfunction

    task automatic chk(string tag, string what, longint act, longint exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin : ref_model
        int  nxt;
        bit  act, act_prev, wstart, wfall, do_a, do_c;
        int  e_mode;
        logic [DW-1:0] e_rd;
        if (!rst_n) begin
            hist = '{3'b111, 3'b111, 3'b111};
            m_state = 0; m_win = 0; m_prog = 0; m_have = 0; m_stb = 0;
            m_addr = '0; m_data = '0;
        end else begin
            act      = (dec_mode(hist[1]) == 2);
            act_prev = (dec_mode(hist[2]) == 2);
            wstart   = act && !act_prev;
            wfall    = hist[2][1] && !hist[1][1];
            nxt = m_state; do_a = 0; do_c = 0;
            if (m_state == 0) begin
                if (wstart) begin nxt = 2; do_a = 1; end
                else if (wfall) nxt = 1;
            end else if (m_state == 1) begin
                if (wstart) begin nxt = 2; do_a = 1; end
                else if (m_win == 0 && !wfall) nxt = m_have ? 3 : 0;
            end else if (m_state == 2) begin
                if (!act) begin nxt = 1; do_c = hist[1][0]; end
            end else begin
                if (m_prog == 0) nxt = 0;
            end
            if (wfall && m_state != 3) m_win = PG;
            else if (m_win > 0) m_win--;
            if (nxt == 3 && m_state != 3) m_prog = PR - 1;
            else if (m_prog > 0) m_prog--;
            m_stb = do_c;
            if (do_a) m_addr = addr;
            if (do_c) m_data = din;
            if (do_c) m_have = 1;
            else if (nxt == 0 || nxt == 3) m_have = 0;
            m_state = nxt;
            hist.push_front({cs_n, we_n, oe_n});
            void'(hist.pop_back());
        end
        #1;
        e_mode = dec_mode(hist[1]);
        e_rd = (m_state == 3) ? {~m_data[DW-1], m_data[DW-2:0]} : arr_q;
        chk("R1/R2/R11", "mode", mode_o, e_mode);
        chk("R1/R2", "rd_oe", rd_oe_o, e_mode == 1);
        chk("R1/R6/R7/R10", "busy", busy_o, m_state == 3);
        chk("R4/R5/R9", "cap_stb", cap_stb_o, m_stb);
        if (m_stb) begin
            chk("R3", "cap_addr", cap_addr_o, m_addr);
            chk("R4", "cap_data", cap_data_o, m_data);
        end
        if (e_mode == 1) chk("R8", "rd_data", rd_data_o, e_rd);
    end

    // ---------------- stimulus ----------------
    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pins(logic c, logic w, logic o);
        @(negedge clk);
        cs_n = c; we_n = w; oe_n = o;
    endtask

    // write-enable-controlled write; address moves and data settles while strobes are low
    task automatic wr_we(logic [AW-1:0] a, logic [DW-1:0] d);
        addr = a; din = ~d;
        pins(1'b0, 1'b1, 1'b1); wait_n(2);
        pins(1'b0, 1'b0, 1'b1); wait_n(4);
        addr = ~a; din = d; wait_n(2);
        pins(1'b0, 1'b1, 1'b1); wait_n(2);
        pins(1'b1, 1'b1, 1'b1);
    endtask

    int busy_seen;

    initial begin
        wait_n(4);
        rst_n = 1'b1;                                  // R1 reset values compared each cycle
        wait_n(3);
        // R2: read, output-off, inhibit, standby sweep
        pins(1'b0, 1'b1, 1'b0); wait_n(5);
        pins(1'b0, 1'b1, 1'b1); wait_n(4);
        pins(1'b0, 1'b0, 1'b0); wait_n(4);
        pins(1'b1, 1'b1, 1'b1); wait_n(4);
        // R3 R4: single write-enable-controlled write, then poll during busy (R8)
        wr_we(17'h1A5A5, 8'hC3);
        wait_n(PG + 6);
        pins(1'b0, 1'b1, 1'b0); wait_n(6);
        // R9: attempt a write while busy
        pins(1'b0, 1'b1, 1'b1); addr = 17'h00777; din = 8'h11;
        pins(1'b0, 1'b0, 1'b1); wait_n(4);
        pins(1'b0, 1'b1, 1'b1); pins(1'b1, 1'b1, 1'b1);
        wait_n(PR + 6);
        // R8: after busy read returns array data
        arr_q = 8'hA7;
        pins(1'b0, 1'b1, 1'b0); wait_n(5);
        pins(1'b1, 1'b1, 1'b1); wait_n(PG + 4);
        // R3 R4: chip-select-controlled write, address moves after start
        addr = 17'h0F0F0; din = 8'h5E;
        pins(1'b1, 1'b0, 1'b1); wait_n(2);
        pins(1'b0, 1'b0, 1'b1); wait_n(4);
        addr = 17'h10101; wait_n(2);
        pins(1'b1, 1'b0, 1'b1); din = 8'h00; wait_n(2);
        pins(1'b1, 1'b1, 1'b1);
        wait_n(PG + PR + 10);
        // R6: page burst, each write-enable fall inside the window
        wr_we(17'h00010, 8'h01);
        wr_we(17'h00011, 8'h82);
        wr_we(17'h00012, 8'h7F);
        busy_seen = 0;
        for (int i = 0; i < PG + 6; i++) begin
            @(negedge clk);
            if (busy_o) busy_seen++;
        end
        chk("R6", "busy during burst tail", busy_seen > 0, 1);
        pins(1'b0, 1'b1, 1'b0); wait_n(4);            // R8 poll of last byte
        pins(1'b1, 1'b1, 1'b1); wait_n(PR + 6);
        // R5: output enable drops while both strobes low
        addr = 17'h00055; din = 8'hEE;
        pins(1'b0, 1'b0, 1'b1); wait_n(5);
        pins(1'b0, 1'b0, 1'b0); wait_n(4);
        pins(1'b1, 1'b1, 1'b1);
        // R10: window expires with no byte pending
        busy_seen = 0;
        for (int i = 0; i < PG + 10; i++) begin
            @(negedge clk);
            if (busy_o) busy_seen++;
        end
        chk("R10", "busy count after empty window", busy_seen, 0);
        pins(1'b1, 1'b0, 1'b1); wait_n(3);
        pins(1'b1, 1'b1, 1'b1); wait_n(PG + 10);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule